// File: doc/BRIEF.md
# Per-Pin Input Debounce Filter for Edge Interrupts

This block sits between the synchronized inputs of a general-purpose port and the edge detector that raises pin interrupts. Each pin has an enable bit held in a 32-bit control word. When a pin's bit is set and the pin is in edge-interrupt mode, a new input level is accepted only when two consecutive debounce sample ticks both see it. A change that does not survive two ticks counts as bounce: it never reaches the filtered level and never produces an edge pulse. Pins in level-interrupt mode, or with the bit clear, pass the raw level through on every system clock.

Sample ticks come from a free-running divider. A 4-bit select field sets the sample period to 2^select source counts. A 1-bit source select picks what the divider counts: every system clock, or the pulses of a second strobe input that stands in for a slower clock source. All logic runs in one clock domain. For every pin the block produces a registered filtered level, plus one-cycle rising and falling pulses taken from changes of that level.

Top module: `gpio_dbnc_filter`

## Requirements
- R1: While `rst` is high and in the cycle after it drops, `dben_rdata`, `lvl_out`, `rise_out` and `fall_out` are all zero. The divider count and the per-pin sample history also clear to zero.
- R2: When `dben_we` is high at a clock edge, `dben_rdata[NUM_PINS-1:0]` takes `dben_wdata[NUM_PINS-1:0]` from that edge onward. Bits 31 down to NUM_PINS always read zero, and writes to them are dropped. Without `dben_we` the word keeps its value.
- R3: For a pin whose enable bit is 0 (bit n controls pin n), `lvl_out[n]` equals the value `pin_in[n]` had at the previous clock edge.
- R4: For a pin with `edge_mode[n]` = 0 (level mode), the enable bit is ignored, and the pin behaves as in R3.
- R5: For a pin with enable bit 1 and `edge_mode[n]` = 1, `lvl_out[n]` changes only at a sample tick where `pin_in[n]` equals the value sampled at the previous tick and differs from `lvl_out[n]`. A level that is present for only one tick never appears on `lvl_out[n]`.
- R6: A sample tick occurs on the source counts whose divider value, taken modulo 2^`smp_sel`, equals 2^`smp_sel`-1. Ticks therefore come every 2^`smp_sel` source counts, and `smp_sel` = 0 gives a tick on every source count.
- R7: With `src_sel` = 0, every system clock is a source count. With `src_sel` = 1, only clocks with `alt_stb` high count, and the divider holds its value otherwise.
- R8: `rise_out[n]` is high for exactly the one cycle in which `lvl_out[n]` has just gone 0 to 1. `fall_out[n]` behaves the same way for 1 to 0. The two are never high together.
- R9: With NUM_PINS = 8, only enable bits 7:0 can be stored, and bits 31:8 of the control word read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dben_we | input | 1 | Write strobe for the enable word |
| dben_wdata | input | 32 | Enable word write data |
| dben_rdata | output | 32 | Enable word read-back, upper bits zero |
| edge_mode | input | NUM_PINS | Per pin: 1 = edge interrupt mode, 0 = level mode |
| smp_sel | input | SEL_W | Sample period exponent |
| src_sel | input | 1 | Divider source: 0 = system clock, 1 = alt_stb |
| alt_stb | input | 1 | Count strobe of the alternate source |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| lvl_out | output | NUM_PINS | Filtered pin levels |
| rise_out | output | NUM_PINS | One-cycle rising edge pulses |
| fall_out | output | NUM_PINS | One-cycle falling edge pulses |

## Verification
The bench targets pulses whose length falls just short of two sample ticks or just reaches it. A filter that accepts on a single tick would let the one-cycle glitch through and raise a rising pulse. One that needs three ticks would accept the two-tick hold one period late. The bench mixes level-mode pins that have their enable bit set with pins that are enabled for edge mode. This catches a design that ignores the mode and delays level-mode pins. It also switches the source to an idle alternate strobe: a divider that kept counting system clocks would accept a held level that must stay blocked. Writes of all ones to the full-width and the 8-pin variants show whether the reserved bits ever read back as set.

// File: rtl/gpio_dbnc_pkg.sv
package gpio_dbnc_pkg;
  localparam int CTRL_W = 32;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } pin_state_t;

  function automatic int cnt_width(input int sel_w);
    return (1 << sel_w) - 1;
  endfunction
endpackage

// File: rtl/gpio_dbnc_cfg.sv
module gpio_dbnc_cfg
  import gpio_dbnc_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [CTRL_W-1:0]   wdata,
  output logic [CTRL_W-1:0]   rdata,
  output logic [NUM_PINS-1:0] en
);
  localparam int PAD_W = CTRL_W - NUM_PINS;

  logic [NUM_PINS-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst)     en_q <= '0;
    else if (we) en_q <= wdata[NUM_PINS-1:0];
  end

  assign en = en_q;

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdata = {{PAD_W{1'b0}}, en_q};
    end else begin : g_full
      assign rdata = en_q;
    end
  endgenerate

  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    $past(we) |-> en == $past(wdata[NUM_PINS-1:0]));
  p_keep_value_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(we) |-> $stable(rdata));
endmodule

// File: rtl/gpio_dbnc_tick.sv
module gpio_dbnc_tick
  import gpio_dbnc_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             src_sel,
  input  logic             alt_stb,
  output logic             tick
);
  localparam int CNT_W = cnt_width(SEL_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic             src_stb;

  assign src_stb = src_sel ? alt_stb : 1'b1;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      mask[i] = (i < int'(sel));
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (src_stb) cnt_q <= cnt_q + 1'b1;
  end

  assign tick = src_stb && ((cnt_q & mask) == mask);

  p_cnt_holds_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(src_stb) |-> $stable(cnt_q));
  p_tick_needs_src_r7: assert property (@(posedge clk) disable iff (rst)
    (src_sel && !alt_stb) |-> !tick);
endmodule

// File: rtl/gpio_dbnc_lane.sv
module gpio_dbnc_lane
  import gpio_dbnc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       filt_en,
  input  logic       tick,
  input  logic       din,
  output pin_state_t st
);
  logic hist_q;
  logic lvl_q;
  logic rise_q;
  logic fall_q;
  logic lvl_nxt;

  always_comb begin
    lvl_nxt = lvl_q;
    if (!filt_en)                     lvl_nxt = din;
    else if (tick && (din == hist_q)) lvl_nxt = din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= 1'b0;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_nxt;
      rise_q <= lvl_nxt & ~lvl_q;
      fall_q <= ~lvl_nxt & lvl_q;
      if (!filt_en || tick) hist_q <= din;
    end
  end

  assign st.lvl  = lvl_q;
  assign st.rise = rise_q;
  assign st.fall = fall_q;

  p_hold_off_tick_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(filt_en) && !$past(tick)) |-> $stable(lvl_q));
  p_two_samples_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(filt_en) && (lvl_q != $past(lvl_q))) |->
      ($past(din) == lvl_q && $past(hist_q) == lvl_q));
  p_rise_matches_r8: assert property (@(posedge clk) disable iff (rst)
    rise_q |-> (lvl_q && !$past(lvl_q)));
  p_fall_matches_r8: assert property (@(posedge clk) disable iff (rst)
    fall_q |-> (!lvl_q && $past(lvl_q)));
  p_excl_edges_r8: assert property (@(posedge clk) disable iff (rst)
    !(rise_q && fall_q));
endmodule

// File: rtl/gpio_dbnc_filter.sv
module gpio_dbnc_filter
  import gpio_dbnc_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int SEL_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dben_we,
  input  logic [31:0]         dben_wdata,
  output logic [31:0]         dben_rdata,
  input  logic [NUM_PINS-1:0] edge_mode,
  input  logic [SEL_W-1:0]    smp_sel,
  input  logic                src_sel,
  input  logic                alt_stb,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] lvl_out,
  output logic [NUM_PINS-1:0] rise_out,
  output logic [NUM_PINS-1:0] fall_out
);
  logic [NUM_PINS-1:0] en;
  logic                tick;

  gpio_dbnc_cfg #(.NUM_PINS(NUM_PINS)) cfg_i (
    .clk   (clk),
    .rst   (rst),
    .we    (dben_we),
    .wdata (dben_wdata),
    .rdata (dben_rdata),
    .en    (en)
  );

  gpio_dbnc_tick #(.SEL_W(SEL_W)) tick_i (
    .clk     (clk),
    .rst     (rst),
    .sel     (smp_sel),
    .src_sel (src_sel),
    .alt_stb (alt_stb),
    .tick    (tick)
  );

  generate
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_lane
      pin_state_t st;
      gpio_dbnc_lane lane_i (
        .clk     (clk),
        .rst     (rst),
        .filt_en (en[n] & edge_mode[n]),
        .tick    (tick),
        .din     (pin_in[n]),
        .st      (st)
      );
      assign lvl_out[n]  = st.lvl;
      assign rise_out[n] = st.rise;
      assign fall_out[n] = st.fall;
    end
  endgenerate

  p_bypass_follows_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(en) == '0) |-> (lvl_out == $past(pin_in)));
  p_level_mode_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(edge_mode) == '0) |-> (lvl_out == $past(pin_in)));
endmodule

// File: tb/gpio_dbnc_filter_tb_top.sv
module gpio_dbnc_filter_tb_top;
  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] emode = '0;
  logic [3:0]  sel = '0;
  logic        srcs = 1'b0;
  logic        alt = 1'b0;
  logic [NP-1:0] pin = '0;
  logic [NP-1:0] lvl, rise, fall;

  logic        n_we = 1'b0;
  logic [31:0] n_wdata = '0;
  logic [31:0] n_rdata;
  logic [7:0]  n_pin = '0;
  logic [7:0]  n_lvl, n_rise, n_fall;

  int checks = 0;
  int fails = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  gpio_dbnc_filter #(.NUM_PINS(NP), .SEL_W(4)) dut_i (
    .clk(clk), .rst(rst), .dben_we(we), .dben_wdata(wdata), .dben_rdata(rdata),
    .edge_mode(emode), .smp_sel(sel), .src_sel(srcs), .alt_stb(alt),
    .pin_in(pin), .lvl_out(lvl), .rise_out(rise), .fall_out(fall));

  gpio_dbnc_filter #(.NUM_PINS(8), .SEL_W(4)) dut_n (
    .clk(clk), .rst(rst), .dben_we(n_we), .dben_wdata(n_wdata), .dben_rdata(n_rdata),
    .edge_mode(8'hFF), .smp_sel(4'd0), .src_sel(1'b0), .alt_stb(1'b0),
    .pin_in(n_pin), .lvl_out(n_lvl), .rise_out(n_rise), .fall_out(n_fall));

  // Reference model built from the requirements
  logic [14:0]   m_cnt;
  logic [NP-1:0] m_en, m_hist, m_lvl, m_rise, m_fall;

  always @(posedge clk) begin : mdl
    logic stb, tk;
    logic [14:0] msk;
    logic [NP-1:0] nx;
    if (rst) begin
      m_cnt <= '0; m_en <= '0; m_hist <= '0;
      m_lvl <= '0; m_rise <= '0; m_fall <= '0;
    end else begin
      stb = srcs ? alt : 1'b1;
      msk = (15'd1 << sel) - 15'd1;
      tk  = stb && ((m_cnt & msk) == msk);
      if (stb) m_cnt <= m_cnt + 15'd1;
      for (int i = 0; i < NP; i++) begin
        if (!(m_en[i] && emode[i])) begin
          nx[i] = pin[i];
          m_hist[i] <= pin[i];
        end else begin
          nx[i] = (tk && pin[i] == m_hist[i]) ? pin[i] : m_lvl[i];
          if (tk) m_hist[i] <= pin[i];
        end
      end
      m_lvl  <= nx;
      m_rise <= nx & ~m_lvl;
      m_fall <= ~nx & m_lvl;
      if (we) m_en <= wdata[NP-1:0];
    end
  end

  function automatic logic [31:0] nxt_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; we = 1'b0; n_we = 1'b0; pin = '0; n_pin = '0; alt = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic sweep(input int sv, input bit sr, input int segs);
    int p;
    do_reset();
    sel = 4'(sv); srcs = sr;
    seed = nxt_rand(seed); emode = seed[NP-1:0];
    seed = nxt_rand(seed);
    wr(seed);
    p = (1 << sv) * 3 * (sr ? 2 : 1);
    for (int s = 0; s < segs; s++) begin
      int len;
      seed = nxt_rand(seed); pin = seed[NP-1:0];
      seed = nxt_rand(seed); len = int'(seed % 32'(p)) + 1;
      for (int c = 0; c < len; c++) begin
        seed = nxt_rand(seed); alt = seed[3];
        @(negedge clk);
        // R3 R4 R5 R6 R7 R8 cycle compare
        check(lvl == m_lvl && rise == m_rise && fall == m_fall,
              "R3/R4/R5/R6/R7/R8 sweep", {lvl, rise}, {m_lvl, m_rise});
      end
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    // R1 during reset
    check(rdata == 0 && lvl == 0 && rise == 0 && fall == 0, "R1 in reset", {rdata[15:0], lvl}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(rdata == 0 && lvl == 0 && rise == 0 && fall == 0, "R1 after reset", {rdata[15:0], lvl}, 0);

    // R2 reserved bits and write/hold
    wr(32'hFFFF_FFFF);
    check(rdata == 32'h0000_FFFF, "R2 reserved bits", rdata, 32'h0000_FFFF);
    @(negedge clk);
    check(rdata == 32'h0000_FFFF, "R2 hold", rdata, 32'h0000_FFFF);
    wr(32'hABCD_1234);
    check(rdata == 32'h0000_1234, "R2 write", rdata, 32'h0000_1234);

    // R9 narrow variant
    @(negedge clk); n_we = 1'b1; n_wdata = 32'hFFFF_FFFF;
    @(negedge clk); n_we = 1'b0;
    check(n_rdata == 32'h0000_00FF, "R9 narrow word", n_rdata, 32'h0000_00FF);
    n_pin = 8'h01;
    @(negedge clk); n_pin = 8'h00;
    repeat (3) @(negedge clk);
    check(n_lvl == 0 && n_rise == 0, "R9 narrow glitch", {n_lvl, n_rise}, 0);

    // R3 bypass: enable 0
    do_reset(); sel = 4'd0; srcs = 1'b0; emode = '1;
    pin = 16'h0001;
    @(negedge clk);
    check(lvl[0] == 1'b1 && rise[0] == 1'b1, "R3 bypass rise", {lvl[0], rise[0]}, 2'b11);
    @(negedge clk);
    check(rise[0] == 1'b0 && lvl[0] == 1'b1, "R8 single pulse", {lvl[0], rise[0]}, 2'b10);
    pin = 16'h0000;
    @(negedge clk);
    check(lvl[0] == 1'b0 && fall[0] == 1'b1, "R8 fall pulse", {lvl[0], fall[0]}, 2'b01);

    // R4 level-mode pin ignores enable
    do_reset(); emode = 16'h0000;
    wr(32'h0000_FFFF);
    pin = 16'h0002;
    @(negedge clk);
    check(lvl[1] == 1'b1 && rise[1] == 1'b1, "R4 level mode", {lvl[1], rise[1]}, 2'b11);

    // R5 one-tick glitch rejected, two-tick hold accepted
    do_reset(); emode = '1;
    wr(32'h0000_0001);
    pin = 16'h0001;
    @(negedge clk); pin = 16'h0000;
    repeat (3) begin
      @(negedge clk);
      check(lvl[0] == 1'b0 && rise[0] == 1'b0, "R5 glitch rejected", {lvl[0], rise[0]}, 0);
    end
    pin = 16'h0001;
    @(negedge clk);
    check(lvl[0] == 1'b0, "R5 first tick", lvl[0], 0);
    @(negedge clk);
    check(lvl[0] == 1'b1 && rise[0] == 1'b1, "R5 second tick", {lvl[0], rise[0]}, 2'b11);

    // R7 idle alternate source blocks acceptance
    do_reset(); emode = '1; srcs = 1'b1; alt = 1'b0;
    wr(32'h0000_0001);
    pin = 16'h0001;
    repeat (20) @(negedge clk);
    check(lvl[0] == 1'b0, "R7 idle source", lvl[0], 0);
    alt = 1'b1;
    repeat (2) @(negedge clk);
    check(lvl[0] == 1'b1, "R7 strobe source", lvl[0], 1);

    // R6 period sweep, random patterns
    for (int sv = 0; sv < 4; sv++) begin
      sweep(sv, 1'b0, 80);
      sweep(sv, 1'b1, 80);
    end
    sweep(10, 1'b0, 12);
    sweep(10, 1'b1, 12);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule